// File: doc/BRIEF.md
# Capture / Compare / PWM Unit

This peripheral serves one pin in one of three ways, chosen by a 4-bit mode field in its control register. In capture mode it watches the pin and, on a qualified edge, copies an external free-running 16-bit timer into its 16-bit value register. In compare mode it watches that same timer against the value register and acts once when they become equal: it drives the pin high or low, only raises the interrupt flag, or raises the flag and sends a one-cycle clear to the timer. In PWM mode it produces a pulse whose width has 10-bit resolution, using an external 8-bit period timer together with its 2-bit sub-count.

Software reaches the unit through a byte-wide register port with a 3-bit address. The timers, their period register and the A/D converter sit outside. The A/D start output is present only when the `ADC_TRIGGER` parameter is 1. When that parameter is 0, the output is tied low.

Top module: `ccp_unit`

## Requirements
- R1: After reset every register reads 0, and all outputs are 0. Register map: address 0 is the control register, with the mode in bits 3:0 and the duty LSBs in bits 5:4. Bits 7:6 of the control register always read 0. Address 1 is the value register low byte and address 2 its high byte. Address 3 holds the 8 duty MSBs. Address 4 holds the flag in bit 0. Every other address reads 0.
- R2: Mode 0000 disables the unit. It raises no flag, it captures nothing, it drives `pinOut` low and it clears the active PWM duty.
- R3: Mode 0101 captures the timer on each rising pin edge and mode 0100 on each falling edge. The opposite edge has no effect. A capture stores the timer value present at the clock edge where the pin change is seen, and it sets the flag.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. Every write to the control register restarts the edge count.
- R5: Mode 1000 drives the pin high on a match and mode 1001 drives it low. Both set the flag. Writing mode 1000 presets the pin low, and writing mode 1001 presets it high.
- R6: Mode 1010 sets only the flag on a match. The pin level is kept.
- R7: Mode 1011 sets the flag on a match, keeps the pin, and drives `timerClear` high for exactly the cycle after the match. `adcStart` pulses with it only while `adcEnable` is high.
- R8: A compare match is acted on only in the first cycle of equality. A match that is held does not fire again.
- R9: Mode 11xx is PWM. The pin is high while {timer8, timerFrac} is below the active 10-bit duty, which is {duty MSB register, control bits 5:4}. Control bits 5:4 have no effect in capture and compare modes.
- R10: The active duty is reloaded only at the clock edge where {timer8, timerFrac} equals {period8, 2'b11}.
- R11: A duty of 0 keeps the pin low. A duty above {period8, 2'b11} keeps it high for the whole period.
- R12: The flag stays set until software writes 0 to address 4. Writing 1 there has no effect. An event in the same cycle as a clear leaves the flag set.
- R13: `pinOe` is high exactly in the compare and PWM modes (mode bit 3 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for reads and writes |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| timer16 | input | 16 | Free-running capture/compare timer |
| timer8 | input | 8 | PWM period timer |
| timerFrac | input | 2 | Sub-count below `timer8` |
| period8 | input | 8 | PWM period value |
| adcEnable | input | 1 | A/D converter enabled |
| pinIn | input | 1 | Pin input level |
| pinOut | output | 1 | Pin output level |
| pinOe | output | 1 | Pin output enable |
| irqFlag | output | 1 | Interrupt flag |
| timerClear | output | 1 | One-cycle clear to the 16-bit timer |
| adcStart | output | 1 | One-cycle A/D start |

## Verification
Capture is driven with single rising and falling pin pulses, and then with trains of 3, 4, 15 and 16 rising edges. These trains separate the four edge qualifiers, and one train is broken by a control write to show that the edge count restarts. Compare is driven with a timer that steps onto the value register and then holds there. This separates each match action from a repeated firing, and the special event is repeated with the A/D enable low and high. PWM is checked through a table of duty and count pairs that sit just below and just at the duty, with LSB steps, zero duty and duty above the period, plus a duty change made mid-period that must not show until the period boundary.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef struct packed {
    logic capLoad;   // copy timer into value register
    logic flagSet;   // raise interrupt flag
    logic latchSet;  // compare: drive pin high
    logic latchClr;  // compare: drive pin low
    logic dutyLoad;  // PWM: move pending duty to active
    logic unitOff;   // mode field is zero
  } ccpStrobes_t;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_VAL_LO = 3'd1;
  localparam logic [2:0] ADDR_VAL_HI = 3'd2;
  localparam logic [2:0] ADDR_DUTY   = 3'd3;
  localparam logic [2:0] ADDR_FLAG   = 3'd4;

  localparam logic [3:0] MODE_OFF     = 4'b0000;
  localparam logic [3:0] MODE_CMP_HI  = 4'b1000;
  localparam logic [3:0] MODE_CMP_LO  = 4'b1001;
  localparam logic [3:0] MODE_CMP_IRQ = 4'b1010;
  localparam logic [3:0] MODE_CMP_EVT = 4'b1011;

endpackage

// File: rtl/ccp_ctrl.sv
module ccp_ctrl
  import ccp_pkg::*;
#(
  parameter int FAST_DIV    = 4,
  parameter int SLOW_DIV    = 16,
  parameter bit ADC_TRIGGER = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  mode,
  input  logic        ctrlWr,
  input  logic        pinIn,
  input  logic        match,
  input  logic        periodEnd,
  input  logic        adcEnable,
  output ccpStrobes_t strobes,
  output logic        timerClear,
  output logic        adcStart
);

  localparam int CNT_W = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_DIV - 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_DIV - 1);

  logic pinPrev, matchPrev;
  logic [CNT_W-1:0] edgeCnt;
  logic rise, fall, capFire, compEvent, specialEvent;
  logic isCapture, isCompare, isPwm;

  assign isCapture = (mode[3:2] == 2'b01);
  assign isCompare = (mode[3:2] == 2'b10);
  assign isPwm     = (mode[3:2] == 2'b11);
  assign rise      = pinIn & ~pinPrev;
  assign fall      = ~pinIn & pinPrev;

  always_comb begin
    unique case (mode[1:0])
      2'b00:   capFire = fall;
      2'b01:   capFire = rise;
      2'b10:   capFire = rise && (edgeCnt == FAST_LAST);
      default: capFire = rise && (edgeCnt == SLOW_LAST);
    endcase
  end

  assign compEvent    = isCompare & match & ~matchPrev;
  assign specialEvent = compEvent && (mode[1:0] == 2'b11);

  always_comb begin
    strobes          = '0;
    strobes.capLoad  = isCapture & capFire;
    strobes.flagSet  = (isCapture & capFire) | compEvent;
    strobes.latchSet = compEvent && (mode[1:0] == 2'b00);
    strobes.latchClr = compEvent && (mode[1:0] == 2'b01);
    strobes.dutyLoad = isPwm & periodEnd;
    strobes.unitOff  = (mode == MODE_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev    <= 1'b0;
      matchPrev  <= 1'b0;
      edgeCnt    <= '0;
      timerClear <= 1'b0;
    end else begin
      pinPrev    <= pinIn;
      matchPrev  <= match;
      timerClear <= specialEvent;
      if (ctrlWr || !isCapture || !mode[1])
        edgeCnt <= '0;
      else if (rise)
        edgeCnt <= capFire ? '0 : edgeCnt + 1'b1;
    end
  end

  generate
    if (ADC_TRIGGER) begin : g_adc
      logic adcQ;
      always_ff @(posedge clk) begin
        if (!rstN) adcQ <= 1'b0;
        else       adcQ <= specialEvent & adcEnable;
      end
      assign adcStart = adcQ;
    end else begin : g_noAdc
      assign adcStart = 1'b0;
    end
  endgenerate

  assert_clear_only_special_R7: assert property (@(posedge clk) disable iff (!rstN)
    timerClear |-> ($past(mode) == MODE_CMP_EVT));
  assert_adc_with_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> timerClear);
  assert_off_silent_R2: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_OFF) |-> (!strobes.flagSet && !strobes.dutyLoad));
  assert_fast_prescale_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capLoad && mode == 4'b0110) |-> (edgeCnt == FAST_LAST));

endmodule

// File: rtl/ccp_datapath.sv
module ccp_datapath
  import ccp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 3,
  parameter int TIMER_W  = 16,
  parameter int PTIMER_W = 8,
  parameter int FRAC_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  ccpStrobes_t         strobes,
  input  logic [TIMER_W-1:0]  timer16,
  input  logic [PTIMER_W-1:0] timer8,
  input  logic [FRAC_W-1:0]   timerFrac,
  input  logic [PTIMER_W-1:0] period8,
  output logic [3:0]          mode,
  output logic                ctrlWr,
  output logic                match,
  output logic                periodEnd,
  output logic                pinOut,
  output logic                pinOe,
  output logic                irqFlag
);

  localparam int DUTY_W = PTIMER_W + FRAC_W;
  localparam int CTRL_W = 4 + FRAC_W;

  logic [CTRL_W-1:0]   ctrlReg;
  logic [TIMER_W-1:0]  valReg;
  logic [PTIMER_W-1:0] dutyHi;
  logic [DUTY_W-1:0]   dutyAct, pwmCount;
  logic                outLatch, flagClr, isPwm;
  logic [3:0]          newMode;

  assign mode      = ctrlReg[3:0];
  assign isPwm     = (mode[3:2] == 2'b11);
  assign ctrlWr    = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
  assign flagClr   = regWrEn && (regAddr == ADDR_W'(ADDR_FLAG)) && !regWrData[0];
  assign newMode   = regWrData[3:0];
  assign pwmCount  = {timer8, timerFrac};
  assign periodEnd = (pwmCount == {period8, {FRAC_W{1'b1}}});
  assign match     = (timer16 == valReg);
  assign pinOut    = isPwm ? (dutyAct > pwmCount) : outLatch;
  assign pinOe     = mode[3];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      valReg   <= '0;
      dutyHi   <= '0;
      dutyAct  <= '0;
      outLatch <= 1'b0;
      irqFlag  <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg <= regWrData[CTRL_W-1:0];
      if (regWrEn && regAddr == ADDR_W'(ADDR_DUTY)) dutyHi <= regWrData[PTIMER_W-1:0];

      if (strobes.capLoad)
        valReg <= timer16;
      else if (regWrEn && regAddr == ADDR_W'(ADDR_VAL_LO))
        valReg[DATA_W-1:0] <= regWrData;
      else if (regWrEn && regAddr == ADDR_W'(ADDR_VAL_HI))
        valReg[TIMER_W-1:DATA_W] <= regWrData[TIMER_W-DATA_W-1:0];

      if (strobes.unitOff)       dutyAct <= '0;
      else if (strobes.dutyLoad) dutyAct <= {dutyHi, ctrlReg[CTRL_W-1:4]};

      if (ctrlWr && (newMode == MODE_CMP_HI || newMode == MODE_OFF))
        outLatch <= 1'b0;
      else if (ctrlWr && newMode == MODE_CMP_LO)
        outLatch <= 1'b1;
      else if (strobes.unitOff)
        outLatch <= 1'b0;
      else if (strobes.latchSet)
        outLatch <= 1'b1;
      else if (strobes.latchClr)
        outLatch <= 1'b0;

      irqFlag <= strobes.flagSet | (irqFlag & ~flagClr);
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_W'(ADDR_CTRL):   regRdData = DATA_W'(ctrlReg);
      ADDR_W'(ADDR_VAL_LO): regRdData = valReg[DATA_W-1:0];
      ADDR_W'(ADDR_VAL_HI): regRdData = DATA_W'(valReg[TIMER_W-1:DATA_W]);
      ADDR_W'(ADDR_DUTY):   regRdData = DATA_W'(dutyHi);
      ADDR_W'(ADDR_FLAG):   regRdData = DATA_W'(irqFlag);
      default:              regRdData = '0;
    endcase
  end

  assert_flag_source_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(strobes.flagSet));
  assert_soft_event_keeps_pin_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flagSet && mode == MODE_CMP_IRQ && !ctrlWr) |=> $stable(outLatch));
  assert_event_beats_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagSet |=> irqFlag);

endmodule

// File: rtl/ccp_unit.sv
module ccp_unit
  import ccp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int TIMER_W     = 16,
  parameter int PTIMER_W    = 8,
  parameter int FRAC_W      = 2,
  parameter int FAST_DIV    = 4,
  parameter int SLOW_DIV    = 16,
  parameter bit ADC_TRIGGER = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  input  logic [TIMER_W-1:0]  timer16,
  input  logic [PTIMER_W-1:0] timer8,
  input  logic [FRAC_W-1:0]   timerFrac,
  input  logic [PTIMER_W-1:0] period8,
  input  logic                adcEnable,
  input  logic                pinIn,
  output logic                pinOut,
  output logic                pinOe,
  output logic                irqFlag,
  output logic                timerClear,
  output logic                adcStart
);

  ccpStrobes_t strobes;
  logic [3:0]  mode;
  logic        ctrlWr, match, periodEnd;

  ccp_ctrl #(
    .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .ADC_TRIGGER(ADC_TRIGGER)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .mode(mode), .ctrlWr(ctrlWr), .pinIn(pinIn),
    .match(match), .periodEnd(periodEnd), .adcEnable(adcEnable),
    .strobes(strobes), .timerClear(timerClear), .adcStart(adcStart)
  );

  ccp_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIMER_W(TIMER_W),
    .PTIMER_W(PTIMER_W), .FRAC_W(FRAC_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strobes(strobes),
    .timer16(timer16), .timer8(timer8), .timerFrac(timerFrac),
    .period8(period8), .mode(mode), .ctrlWr(ctrlWr), .match(match),
    .periodEnd(periodEnd), .pinOut(pinOut), .pinOe(pinOe), .irqFlag(irqFlag)
  );

endmodule

// File: tb/ccp_unit_bench.sv
`timescale 1ns/1ps
module ccp_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic [15:0] timer16 = '0;
  logic [7:0]  timer8 = '0;
  logic [1:0]  timerFrac = '0;
  logic [7:0]  period8 = 8'd9;
  logic        adcEnable = 1'b0;
  logic        pinIn = 1'b0;
  logic        pinOut, pinOe, irqFlag, timerClear, adcStart;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  ccp_unit u_ccp_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timer16(timer16),
    .timer8(timer8), .timerFrac(timerFrac), .period8(period8),
    .adcEnable(adcEnable), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqFlag(irqFlag), .timerClear(timerClear), .adcStart(adcStart)
  );

  // {dutyHi, dutyLsb, timer8, timerFrac, expected pin}, period8 = 9
  localparam int NV = 9;
  localparam logic [20:0] VEC [NV] = '{
    {8'd5,  2'd0, 8'd0, 2'd0, 1'b1},
    {8'd5,  2'd0, 8'd4, 2'd3, 1'b1},
    {8'd5,  2'd0, 8'd5, 2'd0, 1'b0},
    {8'd5,  2'd2, 8'd5, 2'd1, 1'b1},
    {8'd5,  2'd2, 8'd5, 2'd2, 1'b0},
    {8'd0,  2'd0, 8'd0, 2'd0, 1'b0},
    {8'd10, 2'd0, 8'd9, 2'd3, 1'b1},
    {8'd0,  2'd1, 8'd0, 2'd0, 1'b1},
    {8'd0,  2'd1, 8'd0, 2'd1, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    regAddr = a;
    #0.1;
    d = regRdData;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    v = {hi, lo};
  endtask

  task automatic pulse();
    pinIn = 1'b1; tick();
    pinIn = 1'b0; tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), b);
      check("R1 register reset", 16'(b), 16'h0);
    end
    check("R1 outputs reset", {11'b0, pinOut, pinOe, irqFlag, timerClear, adcStart}, 16'h0);
    wr(3'd0, 8'hFF);
    rd(3'd0, b);
    check("R1 ctrl bits 7:6 read zero", 16'(b), 16'h3F);
    check("R13 oe in pwm", 16'(pinOe), 16'h1);
    wr(3'd0, 8'h00);
    check("R13 oe off", 16'(pinOe), 16'h0);

    // R3 rising capture, duty LSBs set (R9 no effect)
    wr(3'd0, 8'h35);
    timer16 = 16'h1234; pinIn = 1'b1; tick();
    rd16(v);
    check("R3 rising capture value", v, 16'h1234);
    check("R3 rising capture flag", 16'(irqFlag), 16'h1);
    wr(3'd4, 8'h00);
    check("R12 flag clear", 16'(irqFlag), 16'h0);
    wr(3'd4, 8'h01);
    check("R12 write one ignored", 16'(irqFlag), 16'h0);
    timer16 = 16'h5555; pinIn = 1'b0; tick();
    rd16(v);
    check("R3 falling ignored in rising mode", v, 16'h1234);
    check("R3 no flag on falling", 16'(irqFlag), 16'h0);

    // R3 falling capture
    wr(3'd0, 8'h04);
    pinIn = 1'b1; tick();
    timer16 = 16'hBEEF; pinIn = 1'b0; tick();
    rd16(v);
    check("R3 falling capture value", v, 16'hBEEF);
    check("R3 falling capture flag", 16'(irqFlag), 16'h1);
    wr(3'd4, 8'h00);

    // R4 every 4th rising edge, restart on ctrl write
    wr(3'd0, 8'h06);
    timer16 = 16'h0111;
    pulse(); pulse();
    wr(3'd0, 8'h06);
    pulse(); pulse(); pulse();
    check("R4 no capture after restart and 3 edges", 16'(irqFlag), 16'h0);
    rd16(v);
    check("R4 value kept", v, 16'hBEEF);
    timer16 = 16'h0444;
    pulse();
    check("R4 4th edge flag", 16'(irqFlag), 16'h1);
    rd16(v);
    check("R4 4th edge value", v, 16'h0444);
    wr(3'd4, 8'h00);

    // R4 every 16th rising edge
    wr(3'd0, 8'h07);
    timer16 = 16'h0777;
    for (int i = 0; i < 15; i++) pulse();
    check("R4 no capture after 15 edges", 16'(irqFlag), 16'h0);
    timer16 = 16'h0888;
    pulse();
    check("R4 16th edge flag", 16'(irqFlag), 16'h1);
    rd16(v);
    check("R4 16th edge value", v, 16'h0888);
    wr(3'd4, 8'h00);

    // R5 compare set high
    timer16 = 16'h0000;
    wr(3'd1, 8'h00);
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h08);
    check("R5 preset low", 16'(pinOut), 16'h0);
    check("R13 oe in compare", 16'(pinOe), 16'h1);
    timer16 = 16'h0100; tick();
    check("R5 match drives high", 16'(pinOut), 16'h1);
    check("R5 match flag", 16'(irqFlag), 16'h1);
    check("R7 no clear outside special", 16'(timerClear), 16'h0);
    wr(3'd4, 8'h00);
    tick();
    check("R8 held match no refire", 16'(irqFlag), 16'h0);

    // R5 compare drive low
    timer16 = 16'h0000; tick();
    wr(3'd0, 8'h09);
    check("R5 preset high", 16'(pinOut), 16'h1);
    timer16 = 16'h0100; tick();
    check("R5 match drives low", 16'(pinOut), 16'h0);
    check("R5 match flag low mode", 16'(irqFlag), 16'h1);
    wr(3'd4, 8'h00);

    // R6 flag only
    timer16 = 16'h0000;
    wr(3'd0, 8'h08);
    timer16 = 16'h0100; tick();
    timer16 = 16'h0000;
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h0A);
    timer16 = 16'h0100; tick();
    check("R6 flag set", 16'(irqFlag), 16'h1);
    check("R6 pin kept high", 16'(pinOut), 16'h1);
    wr(3'd4, 8'h00);

    // R7 special event
    timer16 = 16'h0000;
    wr(3'd0, 8'h0B);
    timer16 = 16'h0100; tick();
    check("R7 flag", 16'(irqFlag), 16'h1);
    check("R7 timer clear pulse", 16'(timerClear), 16'h1);
    check("R7 no adc start when disabled", 16'(adcStart), 16'h0);
    check("R7 pin kept", 16'(pinOut), 16'h1);
    tick();
    check("R7 clear one cycle", 16'(timerClear), 16'h0);
    timer16 = 16'h0000; tick();
    wr(3'd4, 8'h00);
    adcEnable = 1'b1;
    timer16 = 16'h0100; tick();
    check("R7 clear with adc", 16'(timerClear), 16'h1);
    check("R7 adc start", 16'(adcStart), 16'h1);
    tick();
    check("R7 adc start one cycle", 16'(adcStart), 16'h0);

    // R12 event beats clear
    timer16 = 16'h0000; tick();
    timer16 = 16'h0100;
    regWrEn = 1'b1; regAddr = 3'd4; regWrData = 8'h00;
    tick();
    regWrEn = 1'b0;
    check("R12 event wins over clear", 16'(irqFlag), 16'h1);

    // R2 disable
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h00);
    check("R2 pin low when off", 16'(pinOut), 16'h0);
    check("R2 oe off", 16'(pinOe), 16'h0);
    timer16 = 16'h0000; tick();
    timer16 = 16'h0100; tick();
    pulse();
    check("R2 no flag when off", 16'(irqFlag), 16'h0);
    rd16(v);
    check("R2 no capture when off", v, 16'h0100);

    // R9 R11 PWM vectors
    for (int i = 0; i < NV; i++) begin
      wr(3'd3, VEC[i][20:13]);
      wr(3'd0, {2'b00, VEC[i][12:11], 4'b1100});
      timer8 = 8'd9; timerFrac = 2'd3; tick();
      timer8 = VEC[i][10:3]; timerFrac = VEC[i][2:1];
      #0.1;
      check($sformatf("R9 R11 pwm vector %0d", i), 16'(pinOut), 16'(VEC[i][0]));
    end

    // R2 clears active duty
    timer8 = 8'd0; timerFrac = 2'd0;
    wr(3'd3, 8'd5);
    wr(3'd0, 8'h0C);
    timer8 = 8'd9; timerFrac = 2'd3; tick();
    timer8 = 8'd0; timerFrac = 2'd0;
    #0.1;
    check("R9 pwm high before duty", 16'(pinOut), 16'h1);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h0C);
    check("R2 active duty cleared", 16'(pinOut), 16'h0);

    // R10 double buffering
    timer8 = 8'd9; timerFrac = 2'd3; tick();
    timer8 = 8'd0; timerFrac = 2'd0;
    #0.1;
    check("R10 load at period end", 16'(pinOut), 16'h1);
    wr(3'd3, 8'd0);
    check("R10 mid-period write hidden", 16'(pinOut), 16'h1);
    timer8 = 8'd9; timerFrac = 2'd3; tick();
    timer8 = 8'd0; timerFrac = 2'd0;
    #0.1;
    check("R10 new duty after boundary", 16'(pinOut), 16'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule